// File: doc/BRIEF.md
# PCI Interrupt Swizzle Router

This block gathers level-sensitive interrupt requests from a set of PCI devices and delivers them on a 16-line IRQ bus. Each device slot presents a device number, the interrupt pin it uses (INTA to INTD) and a request level. A device pin is first rotated onto one of four shared PIRQ lines. The rotation depends on the device number and the pin, so devices in neighbouring slots spread their INTA requests over different lines.

Each PIRQ line then passes through its own byte-wide routing register. The register either disables the line or names the IRQ number that the line drives. The four routing registers sit in a small configuration window with byte reads and writes. Firmware programs them once at start-up and may change them while requests are active.

If a request arrives on a line that is disabled, it goes nowhere. The block then gives a one-cycle strobe and the index of that line, so that a routing fault can be seen.

Top module: `irq_swizzle_router`

## Requirements
- R1: After reset, all four routing bytes read as 0x80, and irq_o, drop_o and drop_idx_o are all zero.
- R2: The configuration window is four bytes starting at CFG_BASE (0x60). The byte at CFG_BASE+n is the routing register of PIRQ line n, where A=0 and D=3. A read inside the window returns the stored byte. A read at any other address returns 0, and a write there changes no routing byte.
- R3: A device request counts only when its level bit is 1. It is assigned to PIRQ line ((pin-1)+(dev-1)) mod 4, where pin is 1 for INTA up to 4 for INTD and dev is the 5-bit device number. The calculation wraps, so device 0 with INTA lands on line 3.
- R4: A line is enabled when bits 7:4 of its routing byte are all zero. An enabled line drives irq_o bit (byte[3:0]). The output is registered, so it follows an input change at the next clock edge.
- R5: A line whose routing byte is 16 or more never drives any irq_o bit. This holds whether the cause is bit 7 or one of the reserved bits 6:4.
- R6: Each PIRQ line is the OR of all requests mapped to it. Each irq_o bit is the OR of all enabled lines that select it.
- R7: When a device drops its level, the IRQ that its assertion raised falls at the next edge, unless another source still holds that IRQ.
- R8: A request whose pin value is 0, or 5 to 7, is ignored.
- R9: drop_o is high for exactly one cycle when a disabled line changes from no request to request. drop_idx_o gives that line's index during the strobe. If several lines start at once, the lowest index is reported. drop_idx_o is 0 when no strobe is present.
- R10: A write to a routing byte applies at the clock edge that ends the write. irq_o and drop_o, as registered at that same edge, already use the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_num_i | input | N_DEV*5 | Device number of each slot |
| dev_pin_i | input | N_DEV*3 | Interrupt pin of each slot, 1..4 = INTA..INTD |
| dev_lvl_i | input | N_DEV | Request level of each slot |
| cfg_addr_i | input | 8 | Configuration byte address |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data (combinational) |
| irq_o | output | 16 | Registered IRQ lines |
| drop_o | output | 1 | One-cycle strobe for a request on a disabled line |
| drop_idx_o | output | 2 | Index of the dropped PIRQ line |

## Verification
A routing write and a change of request level can fall in the same cycle. Because of the write bypass, the registered IRQ must then reflect the new byte at once, not the old one. The bench holds a request on line A and rewrites that line's target in the same cycle. It expects only the new IRQ bit after that edge. It also rewrites a line to a disabled value while a device starts requesting on it, and expects no IRQ together with a drop strobe for that line.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned NUM_PIRQ  = 4;
  localparam int unsigned PIRQ_W    = 2;
  localparam int unsigned NUM_IRQ   = 16;
  localparam int unsigned IRQ_SEL_W = 4;
  localparam int unsigned DEV_W     = 5;
  localparam int unsigned PIN_W     = 3;

  typedef logic [7:0] route_byte_t;
  typedef route_byte_t [NUM_PIRQ-1:0] route_tbl_t;

  localparam route_byte_t ROUTE_RST = 8'h80;

  function automatic logic pin_valid(input logic [PIN_W-1:0] pin);
    return (pin >= 3'd1) && (pin <= 3'd4);
  endfunction

  // (pin-1)+(dev-1) mod 4, computed in 2-bit wraparound
  function automatic logic [PIRQ_W-1:0] pirq_of(input logic [DEV_W-1:0] dev,
                                                 input logic [PIN_W-1:0] pin);
    return dev[PIRQ_W-1:0] + pin[PIRQ_W-1:0] - 2'd2;
  endfunction

  function automatic logic route_en(input route_byte_t b);
    return b[7:IRQ_SEL_W] == '0;
  endfunction
endpackage

// File: rtl/irq_pin_swizzle.sv
module irq_pin_swizzle
  import irq_route_pkg::*;
#(
  parameter int unsigned N_DEV = 8
) (
  input  logic [N_DEV*DEV_W-1:0] dev_num_i,
  input  logic [N_DEV*PIN_W-1:0] dev_pin_i,
  input  logic [N_DEV-1:0]       dev_lvl_i,
  output logic [NUM_PIRQ-1:0]    pirq_req_o
);
  always_comb begin
    pirq_req_o = '0;
    for (int d = 0; d < N_DEV; d++) begin
      if (dev_lvl_i[d] && pin_valid(dev_pin_i[d*PIN_W +: PIN_W]))
        pirq_req_o[pirq_of(dev_num_i[d*DEV_W +: DEV_W], dev_pin_i[d*PIN_W +: PIN_W])] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter logic [7:0] CFG_BASE = 8'h60
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  cfg_addr_i,
  input  logic        cfg_wr_i,
  input  logic [7:0]  cfg_wdata_i,
  output logic [7:0]  cfg_rdata_o,
  output route_tbl_t  route_q_o,
  output route_tbl_t  route_nxt_o
);
  logic              in_win;
  logic [PIRQ_W-1:0] lane;

  assign in_win = cfg_addr_i[7:PIRQ_W] == CFG_BASE[7:PIRQ_W];
  assign lane   = cfg_addr_i[PIRQ_W-1:0];

  // write bypass: downstream logic sees the byte being written
  always_comb begin
    route_nxt_o = route_q_o;
    if (cfg_wr_i && in_win) route_nxt_o[lane] = cfg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) route_q_o <= {NUM_PIRQ{ROUTE_RST}};
    else         route_q_o <= route_nxt_o;
  end

  assign cfg_rdata_o = in_win ? route_q_o[lane] : 8'h00;
endmodule

// File: rtl/irq_line_map.sv
module irq_line_map
  import irq_route_pkg::*;
(
  input  logic [NUM_PIRQ-1:0] pirq_req_i,
  input  route_tbl_t          route_i,
  output logic [NUM_IRQ-1:0]  irq_d_o,
  output logic [NUM_PIRQ-1:0] pirq_dis_o
);
  always_comb begin
    irq_d_o    = '0;
    pirq_dis_o = '0;
    for (int p = 0; p < NUM_PIRQ; p++) begin
      if (route_en(route_i[p])) begin
        if (pirq_req_i[p]) irq_d_o[route_i[p][IRQ_SEL_W-1:0]] = 1'b1;
      end else begin
        pirq_dis_o[p] = pirq_req_i[p];
      end
    end
  end
endmodule

// File: rtl/irq_swizzle_router.sv
module irq_swizzle_router
  import irq_route_pkg::*;
#(
  parameter int unsigned N_DEV    = 8,
  parameter logic [7:0]  CFG_BASE = 8'h60
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_DEV*DEV_W-1:0] dev_num_i,
  input  logic [N_DEV*PIN_W-1:0] dev_pin_i,
  input  logic [N_DEV-1:0]       dev_lvl_i,
  input  logic [7:0]             cfg_addr_i,
  input  logic                   cfg_wr_i,
  input  logic [7:0]             cfg_wdata_i,
  output logic [7:0]             cfg_rdata_o,
  output logic [NUM_IRQ-1:0]     irq_o,
  output logic                   drop_o,
  output logic [PIRQ_W-1:0]      drop_idx_o
);
  logic [NUM_PIRQ-1:0] pirq_req, pirq_dis, dis_q, dis_rise;
  logic [NUM_IRQ-1:0]  irq_d;
  logic [PIRQ_W-1:0]   rise_idx;
  route_tbl_t          route_q, route_nxt;

  irq_pin_swizzle #(.N_DEV(N_DEV)) u_swz (
    .dev_num_i  (dev_num_i),
    .dev_pin_i  (dev_pin_i),
    .dev_lvl_i  (dev_lvl_i),
    .pirq_req_o (pirq_req)
  );

  irq_route_regs #(.CFG_BASE(CFG_BASE)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .route_q_o   (route_q),
    .route_nxt_o (route_nxt)
  );

  irq_line_map u_map (
    .pirq_req_i (pirq_req),
    .route_i    (route_nxt),
    .irq_d_o    (irq_d),
    .pirq_dis_o (pirq_dis)
  );

  assign dis_rise = pirq_dis & ~dis_q;

  // lowest index wins
  always_comb begin
    rise_idx = '0;
    for (int p = NUM_PIRQ-1; p >= 0; p--)
      if (dis_rise[p]) rise_idx = PIRQ_W'(p);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o      <= '0;
      dis_q      <= '0;
      drop_o     <= 1'b0;
      drop_idx_o <= '0;
    end else begin
      irq_o      <= irq_d;
      dis_q      <= pirq_dis;
      drop_o     <= |dis_rise;
      drop_idx_o <= rise_idx;
    end
  end
endmodule

// File: rtl/irq_swizzle_router_chk.sv
module irq_swizzle_router_chk
  import irq_route_pkg::*;
#(
  parameter int unsigned N_DEV    = 8,
  parameter logic [7:0]  CFG_BASE = 8'h60
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [N_DEV-1:0]      dev_lvl_i,
  input logic [7:0]            cfg_addr_i,
  input logic                  cfg_wr_i,
  input logic [7:0]            cfg_rdata_o,
  input logic [NUM_IRQ-1:0]    irq_o,
  input logic                  drop_o,
  input logic [PIRQ_W-1:0]     drop_idx_o,
  input route_tbl_t            route_q
);
  logic [NUM_IRQ-1:0] sel_mask;
  logic               out_win;

  assign out_win = cfg_addr_i[7:PIRQ_W] != CFG_BASE[7:PIRQ_W];

  always_comb begin
    sel_mask = '0;
    for (int p = 0; p < NUM_PIRQ; p++)
      if (route_en(route_q[p])) sel_mask[route_q[p][IRQ_SEL_W-1:0]] = 1'b1;
  end

  // R4
  irq_only_selected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~sel_mask) == '0);

  // R7
  idle_lowers_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_lvl_i == '0) |=> (irq_o == '0));

  // R9
  drop_on_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> !route_en(route_q[drop_idx_o]));

  // R9
  drop_idx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drop_o |-> (drop_idx_o == '0));

  // R2
  out_win_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_win |-> (cfg_rdata_o == 8'h00));

  // R2
  out_win_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && out_win) |=> $stable(route_q));
endmodule

bind irq_swizzle_router irq_swizzle_router_chk #(.N_DEV(N_DEV), .CFG_BASE(CFG_BASE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dev_lvl_i   (dev_lvl_i),
  .cfg_addr_i  (cfg_addr_i),
  .cfg_wr_i    (cfg_wr_i),
  .cfg_rdata_o (cfg_rdata_o),
  .irq_o       (irq_o),
  .drop_o      (drop_o),
  .drop_idx_o  (drop_idx_o),
  .route_q     (route_q)
);

// File: tb/irq_swizzle_router_bench.sv
`timescale 1ns/1ps
module irq_swizzle_router_bench;
  localparam int N_DEV = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [N_DEV*5-1:0] dev_num_i = '0;
  logic [N_DEV*3-1:0] dev_pin_i = '0;
  logic [N_DEV-1:0]   dev_lvl_i = '0;
  logic [7:0]        cfg_addr_i = '0;
  logic              cfg_wr_i = 1'b0;
  logic [7:0]        cfg_wdata_i = '0;
  logic [7:0]        cfg_rdata_o;
  logic [15:0]       irq_o;
  logic              drop_o;
  logic [1:0]        drop_idx_o;

  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  irq_swizzle_router #(.N_DEV(N_DEV)) u_irq_swizzle_router (
    .clk_i, .rst_ni, .dev_num_i, .dev_pin_i, .dev_lvl_i,
    .cfg_addr_i, .cfg_wr_i, .cfg_wdata_i, .cfg_rdata_o,
    .irq_o, .drop_o, .drop_idx_o
  );

  // {dev[4:0], pin[2:0], expected irq[15:0]} with A->3, B->5, C->9, D->12
  localparam logic [23:0] VEC [12] = '{
    {5'd1,  3'd1, 16'h0008}, {5'd1,  3'd4, 16'h1000},
    {5'd2,  3'd1, 16'h0020}, {5'd3,  3'd2, 16'h1000},
    {5'd6,  3'd3, 16'h1000}, {5'd0,  3'd1, 16'h1000},
    {5'd4,  3'd2, 16'h0008}, {5'd31, 3'd1, 16'h0200},
    {5'd5,  3'd3, 16'h0200}, {5'd2,  3'd0, 16'h0000},
    {5'd2,  3'd5, 16'h0000}, {5'd7,  3'd4, 16'h0020}
  };

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    cfg_addr_i = a; cfg_wdata_i = d; cfg_wr_i = 1'b1;
    step();
    cfg_wr_i = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
    cfg_addr_i = a; #1; d = cfg_rdata_o;
  endtask

  task automatic set_dev(input int s, input logic [4:0] n, input logic [2:0] p, input logic l);
    dev_num_i[s*5 +: 5] = n; dev_pin_i[s*3 +: 3] = p; dev_lvl_i[s] = l;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    #23 rst_ni = 1'b1;
    step();

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      cfg_read(8'h60 + 8'(i), rd);
      check("R1 route byte", {24'h0, rd}, 32'h80);
    end
    check("R1 irq_o", {16'h0, irq_o}, 0);
    check("R1 drop_o", {31'h0, drop_o}, 0);

    // R5 reset routing drops everything
    set_dev(0, 5'd1, 3'd1, 1'b1);
    step();
    check("R5 disabled line quiet", {16'h0, irq_o}, 0);
    set_dev(0, 5'd1, 3'd1, 1'b0);
    step();

    cfg_write(8'h60, 8'h03);
    cfg_write(8'h61, 8'h05);
    cfg_write(8'h62, 8'h09);
    cfg_write(8'h63, 8'h0c);
    cfg_read(8'h62, rd);
    check("R2 readback", {24'h0, rd}, 32'h09);

    // R3 R4 R8 R7 vector walk
    for (int v = 0; v < 12; v++) begin
      set_dev(0, VEC[v][23:19], VEC[v][18:16], 1'b1);
      step();
      check("R3 R4 R8 swizzle route", {16'h0, irq_o}, {16'h0, VEC[v][15:0]});
      dev_lvl_i[0] = 1'b0;
      step();
      check("R7 deassert lowers", {16'h0, irq_o}, 0);
    end

    // R6 two devices on line A, two lines on one IRQ
    set_dev(0, 5'd1, 3'd1, 1'b1);
    set_dev(1, 5'd4, 3'd2, 1'b1);
    step();
    check("R6 shared line", {16'h0, irq_o}, 32'h0008);
    dev_lvl_i[0] = 1'b0;
    step();
    check("R6 one source left", {16'h0, irq_o}, 32'h0008);
    dev_lvl_i[1] = 1'b0;
    step();
    check("R7 all released", {16'h0, irq_o}, 0);
    cfg_write(8'h60, 8'h07);
    cfg_write(8'h61, 8'h07);
    set_dev(0, 5'd1, 3'd1, 1'b1);
    set_dev(1, 5'd2, 3'd1, 1'b1);
    step();
    check("R6 two lines same irq", {16'h0, irq_o}, 32'h0080);
    dev_lvl_i[0] = 1'b0;
    step();
    check("R6 one line left", {16'h0, irq_o}, 32'h0080);
    dev_lvl_i = '0;
    step();

    // R10 retarget line A while it is requesting
    cfg_write(8'h60, 8'h03);
    set_dev(0, 5'd1, 3'd1, 1'b1);
    step();
    check("R10 before write", {16'h0, irq_o}, 32'h0008);
    cfg_write(8'h60, 8'h04);
    check("R10 new route same edge", {16'h0, irq_o}, 32'h0010);

    // R5 R9 R10 disable by reserved bit as request appears on line B
    set_dev(1, 5'd2, 3'd1, 1'b1);
    cfg_write(8'h61, 8'h15);
    check("R5 reserved bit disables", {16'h0, irq_o}, 32'h0010);
    check("R9 strobe", {31'h0, drop_o}, 1);
    check("R9 strobe idx", {30'h0, drop_idx_o}, 1);
    step();
    check("R9 one cycle", {31'h0, drop_o}, 0);
    dev_lvl_i = '0;
    step();

    // R9 lowest index wins
    cfg_write(8'h60, 8'h83);
    cfg_write(8'h62, 8'h49);
    set_dev(0, 5'd1, 3'd1, 1'b1);
    set_dev(1, 5'd3, 3'd1, 1'b1);
    step();
    check("R9 priority strobe", {31'h0, drop_o}, 1);
    check("R9 priority idx", {30'h0, drop_idx_o}, 0);
    check("R5 bit7 disables", {16'h0, irq_o}, 0);
    step();
    check("R9 idx cleared", {30'h0, drop_idx_o}, 0);
    dev_lvl_i = '0;
    step();

    // R2 outside window
    cfg_write(8'h64, 8'h33);
    cfg_write(8'h5f, 8'h44);
    cfg_read(8'h64, rd);
    check("R2 outside read", {24'h0, rd}, 0);
    cfg_read(8'h63, rd);
    check("R2 neighbour untouched", {24'h0, rd}, 32'h0c);
    cfg_read(8'h60, rd);
    check("R2 base untouched", {24'h0, rd}, 32'h83);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule